// File: doc/BRIEF.md
# Accumulator and Link-Bit Operation Unit

This block is the accumulator slice of a small processor datapath. It holds a 16-bit accumulator and a 1-bit link (carry) flag. A sequencer outside the block issues one of four kinds of work per clock. It can issue a register operation, chosen by twelve single-bit selects that come straight from the low bits of an instruction word. It can issue a memory-operand request, which is a load, a bitwise AND or an add with a 16-bit operand. Or it can issue a load of an 8-bit input byte into the low part of the accumulator.

For rotates and increment, the link bit and the accumulator act as a single 17-bit register. The unit also evaluates the skip tests: accumulator sign, accumulator zero and link zero. When one of them holds, it returns a one-cycle skip request that the sequencer uses to advance its program counter. Sequencing, memory and the program counter itself stay outside the block.

Top module: `acl_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `acc` is 0, `link` is 0 and `skipReq` is 0 until an operation is applied.
- R2: When `opStrobe` is high on a rising clock edge, each set bit of `opSel` selects one operation, and the result appears after that edge. The bits are: 11 clear accumulator, 10 clear link, 9 complement accumulator, 8 complement link, 7 rotate right, 6 rotate left, 5 increment, 4 skip if accumulator bit 15 is 0, 3 skip if accumulator bit 15 is 1, 2 skip if accumulator is zero, 1 skip if link is 0, 0 halt.
- R3: Clear sets its target to zero. Complement inverts every bit of its target.
- R4: Rotate right and rotate left move the 17-bit pair {link, acc} circularly by one place. The link bit is the most significant bit of the pair.
- R5: Increment writes acc+1 into acc and writes the carry-out of that sum into link.
- R6: `skipReq` is high for exactly the one cycle after a strobed edge where at least one selected skip test held. The tests use the accumulator and link values from before that edge, so a zero accumulator satisfies bit 4.
- R7: The link changes only for select bits 10, 8, 7, 6 or 5, or for an add request. The halt bit and the skip bits leave acc and link unchanged.
- R8: The `memOp` codes are: 2'b01 loads `operand` into acc, 2'b10 ANDs `operand` into acc, 2'b11 adds `operand` to acc with the carry-out written to link, and 2'b00 does nothing. Load and AND leave link unchanged.
- R9: `inLoad` replaces acc[7:0] with `inByte` and leaves acc[15:8] and link unchanged.
- R10: When several register select bits are set together, they are applied in a fixed order: clears, then complements, then rotate right, then rotate left, then increment.
- R11: Only one kind of work runs per cycle. A strobed register operation takes priority over a memory request, and a memory request takes priority over an input load. The lower-priority requests in that cycle are ignored.
- R12: With `opStrobe` low, `opSel` has no effect on acc, link or `skipReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opStrobe | input | 1 | Applies the register operation selected by `opSel` |
| opSel | input | 12 | One-hot (or combined) register operation selects |
| memOp | input | 2 | Memory-operand request code |
| operand | input | 16 | Operand for memory requests |
| inLoad | input | 1 | Loads `inByte` into the low accumulator byte |
| inByte | input | 8 | Input byte |
| acc | output | 16 | Accumulator |
| link | output | 1 | Link / carry bit |
| skipReq | output | 1 | One-cycle skip request |

## Verification
All of the block's results (acc, link and `skipReq`) are registers, so each one is due on the first rising edge after the cycle that carries the stimulus. The bench drives every request on a falling edge and samples the outputs on the next falling edge, which is half a period after the edge that updates them. To confirm that the skip request is a single-cycle pulse, the bench samples once more a full cycle later, after returning the inputs to idle. Between requests, the accumulator and link are set up through the block's own load and link operations, so every expected value comes from a known starting state.

// File: rtl/acl_pkg.sv
package acl_pkg;

  // Number of register-operation select bits
  localparam int OP_COUNT = 12;

  // Select bit positions (matched to the instruction word layout)
  localparam int SEL_CLR_ACC = 11;
  localparam int SEL_CLR_LNK = 10;
  localparam int SEL_CPL_ACC = 9;
  localparam int SEL_CPL_LNK = 8;
  localparam int SEL_ROT_R   = 7;
  localparam int SEL_ROT_L   = 6;
  localparam int SEL_INCR    = 5;
  localparam int SEL_SKP_POS = 4;
  localparam int SEL_SKP_NEG = 3;
  localparam int SEL_SKP_ZRO = 2;
  localparam int SEL_SKP_LNZ = 1;
  localparam int SEL_HALT    = 0;

  // Memory request codes
  typedef enum logic [1:0] {
    MEM_NONE = 2'b00,
    MEM_LOAD = 2'b01,
    MEM_AND  = 2'b10,
    MEM_ADD  = 2'b11
  } memOp_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic clrAcc;
    logic clrLnk;
    logic cplAcc;
    logic cplLnk;
    logic rotR;
    logic rotL;
    logic incr;
    logic ldLink;
    logic skpPos;
    logic skpNeg;
    logic skpZro;
    logic skpLnz;
    logic memLoad;
    logic memAnd;
    logic memAdd;
    logic inLd;
  } aclStrobes_t;

endpackage

// File: rtl/acl_ctrl.sv
module acl_ctrl
  import acl_pkg::*;
(
  input  logic                opStrobe,
  input  logic [OP_COUNT-1:0] opSel,
  input  logic [1:0]          memOp,
  input  logic                inLoad,
  output aclStrobes_t         stb
);

  logic   regGo;
  logic   memGo;
  logic   inGo;
  memOp_e memCode;

  assign memCode = memOp_e'(memOp);

  // Priority: register op, then memory request, then input byte
  assign regGo = opStrobe;
  assign memGo = !opStrobe && (memCode != MEM_NONE);
  assign inGo  = !opStrobe && (memCode == MEM_NONE) && inLoad;

  always_comb begin
    stb         = '0;
    stb.clrAcc  = regGo && opSel[SEL_CLR_ACC];
    stb.clrLnk  = regGo && opSel[SEL_CLR_LNK];
    stb.cplAcc  = regGo && opSel[SEL_CPL_ACC];
    stb.cplLnk  = regGo && opSel[SEL_CPL_LNK];
    stb.rotR    = regGo && opSel[SEL_ROT_R];
    stb.rotL    = regGo && opSel[SEL_ROT_L];
    stb.incr    = regGo && opSel[SEL_INCR];
    stb.ldLink  = regGo && (opSel[SEL_CLR_LNK] || opSel[SEL_CPL_LNK] ||
                            opSel[SEL_ROT_R]   || opSel[SEL_ROT_L]   ||
                            opSel[SEL_INCR]);
    stb.skpPos  = regGo && opSel[SEL_SKP_POS];
    stb.skpNeg  = regGo && opSel[SEL_SKP_NEG];
    stb.skpZro  = regGo && opSel[SEL_SKP_ZRO];
    stb.skpLnz  = regGo && opSel[SEL_SKP_LNZ];
    stb.memLoad = memGo && (memCode == MEM_LOAD);
    stb.memAnd  = memGo && (memCode == MEM_AND);
    stb.memAdd  = memGo && (memCode == MEM_ADD);
    stb.inLd    = inGo;
  end

  // R11: at most one class of work is active per cycle
  always_comb begin
    p_one_class_r11: assert ($onehot0({regGo, memGo, inGo}));
  end

endmodule

// File: rtl/acl_datapath.sv
module acl_datapath
  import acl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  aclStrobes_t       stb,
  input  logic [DATA_W-1:0] operand,
  input  logic [IO_W-1:0]   inByte,
  output logic [DATA_W-1:0] acc,
  output logic              link,
  output logic              skipReq
);

  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0]  work;
  logic [DATA_W-1:0] inMerged;
  logic [DATA_W-1:0] accNext;
  logic              linkNext;
  logic              skipNext;

  // Input byte merge: the variant depends on the relative widths
  generate
    if (IO_W >= DATA_W) begin : g_inFull
      assign inMerged = inByte[DATA_W-1:0];
    end else begin : g_inLow
      assign inMerged = {acc[DATA_W-1:IO_W], inByte};

      // R9: input load keeps the upper accumulator bits
      p_upper_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stb.inLd |=> acc[DATA_W-1:IO_W] == $past(acc[DATA_W-1:IO_W]));
    end
  endgenerate

  // Ordered operation chain on the joined {link, acc} value
  always_comb begin
    work = {link, acc};
    if (stb.clrAcc) work[DATA_W-1:0] = '0;
    if (stb.clrLnk) work[DATA_W]     = 1'b0;
    if (stb.cplAcc) work[DATA_W-1:0] = ~work[DATA_W-1:0];
    if (stb.cplLnk) work[DATA_W]     = ~work[DATA_W];
    if (stb.rotR)   work = {work[0], work[EXT_W-1:1]};
    if (stb.rotL)   work = {work[EXT_W-2:0], work[EXT_W-1]};
    if (stb.incr)   work = {1'b0, work[DATA_W-1:0]} + EXT_W'(1);
    if (stb.memLoad) work[DATA_W-1:0] = operand;
    if (stb.memAnd)  work[DATA_W-1:0] = work[DATA_W-1:0] & operand;
    if (stb.memAdd)  work = {1'b0, acc} + {1'b0, operand};
    if (stb.inLd)    work[DATA_W-1:0] = inMerged;
  end

  assign accNext  = work[DATA_W-1:0];
  assign linkNext = (stb.ldLink || stb.memAdd) ? work[DATA_W] : link;

  // Skip tests use the values held before the edge
  assign skipNext = (stb.skpPos && !acc[DATA_W-1]) ||
                    (stb.skpNeg &&  acc[DATA_W-1]) ||
                    (stb.skpZro && (acc == '0))    ||
                    (stb.skpLnz && !link);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      link    <= 1'b0;
      skipReq <= 1'b0;
    end else begin
      acc     <= accNext;
      link    <= linkNext;
      skipReq <= skipNext;
    end
  end

  // R7: link is held unless a link-writing operation or an add ran
  p_link_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.ldLink || stb.memAdd) |=> link == $past(link));

  // R6: a skip request follows a cycle that enabled some skip test
  p_skip_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    skipReq |-> $past(stb.skpPos || stb.skpNeg || stb.skpZro || stb.skpLnz));

  // R6: an enabled zero test on a zero accumulator always raises skip
  p_skip_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.skpZro && acc == '0) |=> skipReq);

  // R8: load and AND leave link unchanged
  p_mem_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.memLoad || stb.memAnd) |=> $stable(link));

endmodule

// File: rtl/acl_unit.sv
module acl_unit
  import acl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IO_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                opStrobe,
  input  logic [OP_COUNT-1:0] opSel,
  input  logic [1:0]          memOp,
  input  logic [DATA_W-1:0]   operand,
  input  logic                inLoad,
  input  logic [IO_W-1:0]     inByte,
  output logic [DATA_W-1:0]   acc,
  output logic                link,
  output logic                skipReq
);

  aclStrobes_t stb;

  acl_ctrl u_ctrl (
    .opStrobe (opStrobe),
    .opSel    (opSel),
    .memOp    (memOp),
    .inLoad   (inLoad),
    .stb      (stb)
  );

  acl_datapath #(
    .DATA_W (DATA_W),
    .IO_W   (IO_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .operand (operand),
    .inByte  (inByte),
    .acc     (acc),
    .link    (link),
    .skipReq (skipReq)
  );

  // R7: a lone halt select leaves the accumulator and link alone
  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (opStrobe && opSel == OP_COUNT'(1) << SEL_HALT) |=> (acc == $past(acc) && link == $past(link)));

  // R3: a lone clear-accumulator select empties the accumulator
  p_clr_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (opStrobe && opSel == OP_COUNT'(1) << SEL_CLR_ACC) |=> acc == '0);

  // R12: no skip request without a strobe in the previous cycle
  p_skip_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    skipReq |-> $past(opStrobe));

endmodule

// File: tb/tb_acl_unit.sv
`timescale 1ns/1ps
module tb_acl_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opStrobe = 1'b0;
  logic [11:0] opSel = '0;
  logic [1:0]  memOp = '0;
  logic [15:0] operand = '0;
  logic        inLoad = 1'b0;
  logic [7:0]  inByte = '0;
  logic [15:0] acc;
  logic        link;
  logic        skipReq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  acl_unit dut (
    .clk(clk), .rst_n(rst_n), .opStrobe(opStrobe), .opSel(opSel),
    .memOp(memOp), .operand(operand), .inLoad(inLoad), .inByte(inByte),
    .acc(acc), .link(link), .skipReq(skipReq)
  );

  logic [15:0] vals [8] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF,
                            16'h0001, 16'h1234, 16'hA5C3, 16'hFFFE};

  task automatic check(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus at a falling edge, sample at the next falling edge
  task automatic step(input bit s, input logic [11:0] sel, input logic [1:0] m,
                      input logic [15:0] opnd, input bit il, input logic [7:0] ib);
    @(negedge clk);
    opStrobe = s; opSel = sel; memOp = m; operand = opnd; inLoad = il; inByte = ib;
    @(negedge clk);
    opStrobe = 1'b0; opSel = '0; memOp = '0; operand = '0; inLoad = 1'b0; inByte = '0;
  endtask

  task automatic setState(input logic [15:0] a, input bit e);
    step(1'b0, '0, 2'b01, a, 1'b0, '0);
    step(1'b1, 12'h400, 2'b00, '0, 1'b0, '0);
    if (e) step(1'b1, 12'h100, 2'b00, '0, 1'b0, '0);
  endtask

  function automatic logic [16:0] modelReg(input logic [15:0] a, input logic e, input logic [11:0] s);
    logic [16:0] x;
    x = {e, a};
    if (s[11]) x[15:0] = 16'h0000;
    if (s[10]) x[16] = 1'b0;
    if (s[9])  x[15:0] = ~x[15:0];
    if (s[8])  x[16] = ~x[16];
    if (s[7])  x = (x >> 1) | ({16'h0, x[0]} << 16);
    if (s[6])  x = (x << 1) | {16'h0, x[16]};
    if (s[5])  x = {1'b0, x[15:0]} + 17'd1;
    return x;
  endfunction

  function automatic logic modelSkip(input logic [15:0] a, input logic e, input logic [11:0] s);
    return (s[4] && !a[15]) || (s[3] && a[15]) || (s[2] && a == 16'h0) || (s[1] && !e);
  endfunction

  task automatic regCase(input logic [15:0] a, input bit e, input logic [11:0] s, input string req);
    logic [16:0] ex;
    logic        sk;
    setState(a, e);
    ex = modelReg(a, e, s);
    sk = modelSkip(a, e, s);
    step(1'b1, s, 2'b00, '0, 1'b0, '0);
    check({link, acc, skipReq} == {ex, sk}, req, {link, acc, skipReq}, {ex, sk});
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [11:0] combos [6] = '{12'h A00, 12'h 420, 12'h 2C0, 12'h 6A0, 12'h 01C, 12'h 81F};
    // R1: reset state
    #3;
    check({link, acc, skipReq} == 18'h0, "R1 during reset", {link, acc, skipReq}, 18'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({link, acc, skipReq} == 18'h0, "R1 after reset", {link, acc, skipReq}, 18'h0);

    // R2 R3 R4 R5 R6 R7: every single select over a spread of states
    for (int b = 0; b < 12; b++) begin
      for (int v = 0; v < 8; v++) begin
        for (int e = 0; e < 2; e++) begin
          regCase(vals[v], e[0], 12'h001 << b, "R2/R3/R4/R5/R6/R7 single select");
        end
      end
    end

    // R6: skip pulse lasts one cycle
    setState(16'h0000, 1'b0);
    step(1'b1, 12'h004, 2'b00, '0, 1'b0, '0);
    check(skipReq == 1'b1, "R6 skip raised", {17'h0, skipReq}, 18'h1);
    @(negedge clk);
    check(skipReq == 1'b0, "R6 skip one cycle", {17'h0, skipReq}, 18'h0);

    // R10: combined selects in fixed order
    for (int c = 0; c < 6; c++) begin
      for (int v = 0; v < 8; v++) begin
        regCase(vals[v], v[0], combos[c], "R10 combined order");
      end
    end

    // R8: memory requests
    for (int v = 0; v < 8; v++) begin
      for (int w = 0; w < 8; w += 3) begin
        for (int m = 1; m < 4; m++) begin
          logic [16:0] ex;
          setState(vals[v], w[0]);
          case (m)
            1: ex = {w[0], vals[w]};
            2: ex = {w[0], vals[v] & vals[w]};
            default: ex = {1'b0, vals[v]} + {1'b0, vals[w]};
          endcase
          step(1'b0, '0, m[1:0], vals[w], 1'b0, '0);
          check({link, acc} == ex, "R8 memory request", {1'b0, link, acc}, {1'b0, ex});
        end
      end
    end

    // R9: input byte load
    for (int v = 0; v < 8; v++) begin
      logic [7:0] ib;
      ib = 8'h5A ^ 8'(v * 37);
      setState(vals[v], v[1]);
      step(1'b0, '0, 2'b00, '0, 1'b1, ib);
      check({link, acc} == {v[1], vals[v][15:8], ib}, "R9 input byte",
            {1'b0, link, acc}, {1'b0, v[1], vals[v][15:8], ib});
    end

    // R11: priority among simultaneous requests
    setState(16'h1234, 1'b0);
    step(1'b1, 12'h200, 2'b01, 16'hBEEF, 1'b1, 8'h77);
    check({link, acc} == {1'b0, 16'hEDCB}, "R11 register op wins",
          {1'b0, link, acc}, {2'b00, 16'hEDCB});
    setState(16'h1234, 1'b1);
    step(1'b0, '0, 2'b01, 16'hBEEF, 1'b1, 8'h77);
    check({link, acc} == {1'b1, 16'hBEEF}, "R11 memory wins over input",
          {1'b0, link, acc}, {2'b01, 16'hBEEF});

    // R12: selects without strobe are ignored
    setState(16'h0000, 1'b1);
    step(1'b0, 12'hFFF, 2'b00, '0, 1'b0, '0);
    check({link, acc, skipReq} == {1'b1, 16'h0000, 1'b0}, "R12 no strobe",
          {link, acc, skipReq}, {1'b1, 16'h0000, 1'b0});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule